// File: doc/BRIEF.md
# Chip Reset Sequencer with Configuration Straps

This block merges the two chip reset sources, a synchronised external reset pin and a watchdog request, into one internal reset. A counter filters the pin so that brief pulses are ignored. Any accepted reset request restarts a wakeup counter. The internal reset is held until several conditions all hold at once: the pin has been released, the oscillator is ready, the wakeup count has elapsed, on-chip initialisation reports done, and flash high voltages have settled.

Configuration strap inputs are captured only while an accepted pin reset is present. A watchdog reset leaves the captured values untouched. A two-bit cause field records the source of the most recent reset. Two constant outputs carry the execution start address taken after release and the default value of the peripheral power-enable register. The block runs on the always-on clock and has its own power-on reset.

Top module: `chip_reset_seq`

## Requirements
- R1: A one-cycle `wdog_pulse` sampled high at a clock edge drives `sys_rst` high from that edge onward. An accepted pin reset also drives `sys_rst` high.
- R2: `pin_rst_in` (1 = asserted) is accepted only after it is sampled high on GLITCH_CYCLES consecutive edges (default 4). Reset begins at that edge. A shorter pulse leaves `sys_rst`, `rst_cause` and `strap_q` unchanged.
- R3: `sys_rst` falls only at an edge where all of these hold: the filtered pin is low, `osc_ready` is 1, `init_done` is 1, and the wakeup counter has reached WAKE_CYCLES (default 16). The counter advances only on edges where `osc_ready` is 1. With every condition already met, reset lasts WAKE_CYCLES+1 cycles from its start edge.
- R4: `strap_q` loads `strap_in` on each edge while the filtered pin reset is active. A watchdog reset leaves `strap_q` unchanged.
- R5: While `flash_busy` is 1, `sys_rst` stays high. Release happens no earlier than the first edge that samples `flash_busy` at 0.
- R6: `rst_cause` is updated at the start edge of each reset: 2'b01 for a pin reset and 2'b10 for a watchdog reset. A pin reset takes priority if both start on the same edge.
- R7: A new reset request while reset is held restarts the wakeup count from zero.
- R8: `boot_vector` is constant zero. `pwr_en_default` is constant with all bits set to 1.
- R9: While `rst_por_n` is low: `sys_rst` is 1, `rst_cause` is 2'b01, and `strap_q` equals STRAP_DEFAULT. After power-on reset is released, `sys_rst` follows the same release rules as R3.
- R10: A single-cycle watchdog pulse keeps `sys_rst` high through the complete wakeup sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_in | input | 1 | Synchronised external reset pin, 1 = asserted |
| wdog_pulse | input | 1 | Watchdog reset request, one-cycle pulse |
| osc_ready | input | 1 | Oscillator running and stable |
| init_done | input | 1 | On-chip initialisation finished |
| flash_busy | input | 1 | Flash high voltages not yet settled |
| strap_in | input | STRAP_W | Configuration strap pins |
| sys_rst | output | 1 | Internal chip reset, 1 = asserted |
| strap_q | output | STRAP_W | Captured strap values |
| rst_cause | output | 2 | Source of the last reset |
| boot_vector | output | ADDR_W | Start address after release (zero) |
| pwr_en_default | output | N_PERIPH | Power-enable register reset value |

## Verification
On every cycle, the in-line properties check the following. A release never happens unless every gating condition held in the cycle before it. Reset stays up while flash is busy. The wakeup counter stays frozen whenever the oscillator is down. Straps never move unless a filtered pin reset is present. A watchdog pulse always produces reset and the watchdog cause code. Only the bench scenarios can show that reset lasts the exact cycle count expected when conditions are released at staggered times, that a three-cycle pin pulse leaves every output untouched, and that a second request part-way through restarts the count.

// File: rtl/crs_pkg.sv
package crs_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_PIN  = 2'b01,
      CAUSE_WDOG = 2'b10
   } cause_e;
endpackage

// File: rtl/crs_glitch_filter.sv
module crs_glitch_filter #(
   parameter int unsigned GLITCH_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic start
);
   if (GLITCH_CYCLES < 1) begin : g_bad_len
      $error("GLITCH_CYCLES must be at least 1");
   end

   if (GLITCH_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level <= 1'b0;
         else        level <= raw;
      end
      assign start = raw && !level;
   end else begin : g_count
      localparam int unsigned CW = $clog2(GLITCH_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);
      logic [CW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_cnt <= '0;
            level   <= 1'b0;
         end else if (!raw) begin
            run_cnt <= '0;
            level   <= 1'b0;
         end else if (run_cnt == LAST) begin
            level   <= 1'b1;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
      assign start = raw && !level && (run_cnt == LAST);

      // R2: acceptance only after the full run of high samples
      p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(level) |-> ($past(run_cnt) == LAST) && $past(raw));
   end

   // R2: a low sample drops the filtered level at once
   p_drop_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !raw |=> !level);
endmodule

// File: rtl/crs_wake_timer.sv
module crs_wake_timer #(
   parameter int unsigned WAKE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic advance,
   output logic done
);
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("WAKE_CYCLES must be at least 1");
   end

   localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
   localparam logic [CW-1:0] TOP = CW'(WAKE_CYCLES);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (restart)            cnt <= '0;
      else if (advance && !done)   cnt <= cnt + 1'b1;
   end
   assign done = (cnt == TOP);

   // R3: counter never passes its limit
   p_wake_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);
   // R3: no progress without the oscillator
   p_hold_without_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(cnt));
   // R7: a restart clears the count
   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
endmodule

// File: rtl/crs_strap_latch.sv
module crs_strap_latch #(
   parameter int unsigned          STRAP_W       = 8,
   parameter logic [STRAP_W-1:0]   STRAP_DEFAULT = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [STRAP_W-1:0] d,
   output logic [STRAP_W-1:0] q
);
   for (genvar b = 0; b < STRAP_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[b] <= STRAP_DEFAULT[b];
         else if (capture) q[b] <= d[b];
      end
   end

   // R4: straps move only while a filtered pin reset is present
   p_strap_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(q));
endmodule

// File: rtl/chip_reset_seq.sv
module chip_reset_seq
   import crs_pkg::*;
#(
   parameter int unsigned        GLITCH_CYCLES = 4,
   parameter int unsigned        WAKE_CYCLES   = 16,
   parameter int unsigned        STRAP_W       = 8,
   parameter logic [STRAP_W-1:0] STRAP_DEFAULT = '0,
   parameter int unsigned        ADDR_W        = 32,
   parameter int unsigned        N_PERIPH      = 32
) (
   input  logic                clk,
   input  logic                rst_por_n,
   input  logic                pin_rst_in,
   input  logic                wdog_pulse,
   input  logic                osc_ready,
   input  logic                init_done,
   input  logic                flash_busy,
   input  logic [STRAP_W-1:0]  strap_in,
   output logic                sys_rst,
   output logic [STRAP_W-1:0]  strap_q,
   output logic [1:0]          rst_cause,
   output logic [ADDR_W-1:0]   boot_vector,
   output logic [N_PERIPH-1:0] pwr_en_default
);
   if (STRAP_W < 1 || ADDR_W < 1 || N_PERIPH < 1) begin : g_bad_width
      $error("widths must be at least 1");
   end

   logic pin_level, pin_start, any_start, wake_done, release_ok;
   cause_e cause_q;

   crs_glitch_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filter (
      .clk(clk), .rst_n(rst_por_n), .raw(pin_rst_in),
      .level(pin_level), .start(pin_start));

   assign any_start = pin_start || wdog_pulse;

   crs_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk(clk), .rst_n(rst_por_n), .restart(any_start),
      .advance(sys_rst && osc_ready), .done(wake_done));

   crs_strap_latch #(.STRAP_W(STRAP_W), .STRAP_DEFAULT(STRAP_DEFAULT)) u_straps (
      .clk(clk), .rst_n(rst_por_n), .capture(pin_level),
      .d(strap_in), .q(strap_q));

   assign release_ok = wake_done && osc_ready && init_done && !flash_busy && !pin_level;

   always_ff @(posedge clk or negedge rst_por_n) begin
      if (!rst_por_n) begin
         sys_rst <= 1'b1;
         cause_q <= CAUSE_PIN;
      end else begin
         if (any_start)                   sys_rst <= 1'b1;
         else if (sys_rst && release_ok)  sys_rst <= 1'b0;
         if (pin_start)                   cause_q <= CAUSE_PIN;
         else if (wdog_pulse)             cause_q <= CAUSE_WDOG;
      end
   end

   assign rst_cause      = cause_q;
   assign boot_vector    = '0;
   assign pwr_en_default = '1;

   // R1 / R10: a watchdog pulse always yields reset
   p_wdog_asserts_r1: assert property (@(posedge clk) disable iff (!rst_por_n)
      wdog_pulse |=> sys_rst);
   // R3: release only when every gate held
   p_release_gates_r3: assert property (@(posedge clk) disable iff (!rst_por_n)
      $fell(sys_rst) |-> $past(osc_ready && init_done && !pin_level && wake_done));
   // R5: flash settling holds reset
   p_flash_hold_r5: assert property (@(posedge clk) disable iff (!rst_por_n)
      (sys_rst && flash_busy) |=> sys_rst);
   // R6: watchdog cause code
   p_cause_wdog_r6: assert property (@(posedge clk) disable iff (!rst_por_n)
      (wdog_pulse && !pin_start) |=> (rst_cause == 2'b10));
   // R6: pin cause code
   p_cause_pin_r6: assert property (@(posedge clk) disable iff (!rst_por_n)
      pin_start |=> (rst_cause == 2'b01));
endmodule

// File: tb/chip_reset_seq_test.sv
module chip_reset_seq_test;
   localparam int G = 4;
   localparam int W = 16;
   localparam logic [7:0] SDEF = 8'h3C;

   logic clk = 1'b0;
   logic rst_por_n, pin_rst_in, wdog_pulse, osc_ready, init_done, flash_busy;
   logic [7:0] strap_in, strap_q;
   logic sys_rst;
   logic [1:0] rst_cause;
   logic [31:0] boot_vector, pwr_en_default;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   logic [7:0] last_strap;

   chip_reset_seq #(.GLITCH_CYCLES(G), .WAKE_CYCLES(W), .STRAP_W(8),
                    .STRAP_DEFAULT(SDEF), .ADDR_W(32), .N_PERIPH(32)) uut (
      .clk(clk), .rst_por_n(rst_por_n), .pin_rst_in(pin_rst_in),
      .wdog_pulse(wdog_pulse), .osc_ready(osc_ready), .init_done(init_done),
      .flash_busy(flash_busy), .strap_in(strap_in), .sys_rst(sys_rst),
      .strap_q(strap_q), .rst_cause(rst_cause), .boot_vector(boot_vector),
      .pwr_en_default(pwr_en_default));

   always #10 clk = ~clk;

   // fields: is_pin, pin edges held, osc-low steps, busy steps, init-low steps
   localparam int NV = 7;
   localparam int VEC [NV][5] = '{
      '{0, 0,  0,  0,  0},
      '{0, 0,  6,  0,  0},
      '{0, 0,  0, 40,  0},
      '{0, 0,  0,  0, 25},
      '{1, 4,  0,  0,  0},
      '{1, 30, 0,  0,  0},
      '{1, 5,  3, 10,  0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic idle();
      pin_rst_in = 0; wdog_pulse = 0; osc_ready = 1; init_done = 1; flash_busy = 0;
      repeat (3) @(negedge clk);
   endtask

   // returns number of cycles sys_rst stayed high from step 0
   task automatic run_case(input bit is_pin, input int n, input int k, input int b,
                           input int i, input logic [7:0] s, input string tag,
                           output int len, output logic [1:0] cause0);
      len = 0; cause0 = 2'b00;
      @(negedge clk);
      strap_in = s;
      if (k > 0) osc_ready = 0;
      if (b > 0) flash_busy = 1;
      if (i > 0) init_done = 0;
      if (is_pin) begin
         pin_rst_in = 1;
         repeat (G) @(negedge clk);
      end else begin
         wdog_pulse = 1;
         @(negedge clk);
         wdog_pulse = 0;
      end
      for (int j = 0; j < 400; j++) begin
         if (j == 0) cause0 = rst_cause;
         if (!sys_rst) break;
         len++;
         if (j == k) osc_ready = 1;
         if (j == b) flash_busy = 0;
         if (j == i) init_done = 1;
         if (is_pin && j == n - G) pin_rst_in = 0;
         @(negedge clk);
      end
      if (tag.len() == 0) len = len;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      int len;
      logic [1:0] c0;
      rst_por_n = 0; pin_rst_in = 0; wdog_pulse = 0; osc_ready = 1;
      init_done = 1; flash_busy = 0; strap_in = 8'h00;
      repeat (3) @(negedge clk);
      // R9: power-on state
      check(sys_rst == 1'b1, "R9 por sys_rst", int'(sys_rst), 1);
      check(rst_cause == 2'b01, "R9 por cause", int'(rst_cause), 1);
      check(strap_q == SDEF, "R9 por straps", int'(strap_q), int'(SDEF));
      // R8: constants
      check(boot_vector == 32'h0, "R8 boot vector", int'(boot_vector), 0);
      check(pwr_en_default == 32'hFFFF_FFFF, "R8 power enables", int'(pwr_en_default), -1);
      rst_por_n = 1;
      len = 0;
      for (int j = 0; j < 100; j++) begin
         if (!sys_rst) break;
         len++;
         @(negedge clk);
      end
      check(len == W + 1, "R9 por release length", len, W + 1);
      last_strap = SDEF;
      idle();

      // table walk: R1 R3 R4 R5 R6 R10 R2
      for (int v = 0; v < NV; v++) begin
         logic [7:0] s;
         int exp;
         bit p;
         p = (VEC[v][0] != 0);
         s = p ? (8'hA0 + 8'(v)) : 8'h5A;
         exp = imax(VEC[v][2] + W + 1, imax(VEC[v][3] + 1, VEC[v][4] + 1));
         if (p) exp = imax(exp, VEC[v][1] - G + 2);
         run_case(p, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], s, "v", len, c0);
         check(len == exp, "R3/R5/R10 reset length", len, exp);
         check(c0 == (p ? 2'b01 : 2'b10), "R6 cause code", int'(c0), p ? 1 : 2);
         if (p) last_strap = s;
         check(strap_q == last_strap, "R4 strap capture", int'(strap_q), int'(last_strap));
         idle();
      end

      // R2: pulse one edge short of acceptance has no effect
      begin
         logic [1:0] cprev;
         bit stayed;
         cprev = rst_cause;
         @(negedge clk);
         strap_in = 8'hEE;
         pin_rst_in = 1;
         repeat (G - 1) @(negedge clk);
         pin_rst_in = 0;
         stayed = 1;
         for (int j = 0; j < 6; j++) begin
            if (sys_rst) stayed = 0;
            @(negedge clk);
         end
         check(stayed, "R2 short pulse no reset", int'(!stayed), 0);
         check(rst_cause == cprev, "R2 short pulse cause kept", int'(rst_cause), int'(cprev));
         check(strap_q == last_strap, "R2 short pulse straps kept", int'(strap_q), int'(last_strap));
      end
      idle();

      // R7: second watchdog pulse restarts the wakeup count
      @(negedge clk);
      wdog_pulse = 1;
      @(negedge clk);
      wdog_pulse = 0;
      len = 0;
      for (int j = 0; j < 100; j++) begin
         if (!sys_rst) break;
         len++;
         wdog_pulse = (j == 5);
         @(negedge clk);
      end
      check(len == W + 7, "R7 restart length", len, W + 7);
      check(rst_cause == 2'b10, "R6 cause after restart", int'(rst_cause), 2);
      idle();

      // R1: pin reset asserts sys_rst at the acceptance edge
      @(negedge clk);
      pin_rst_in = 1;
      repeat (G - 1) @(negedge clk);
      check(sys_rst == 1'b0, "R1 not yet asserted", int'(sys_rst), 0);
      @(negedge clk);
      check(sys_rst == 1'b1, "R1 pin asserts reset", int'(sys_rst), 1);
      pin_rst_in = 0;
      repeat (W + 4) @(negedge clk);
      check(sys_rst == 1'b0, "R3 released after pin", int'(sys_rst), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule